// File: doc/BRIEF.md
# Programmable Baud Divisor

This block turns a reference-rate enable into the sample-rate strobe of a serial port. Software loads a 16-bit divisor one byte at a time through two byte write strobes that share one data bus. Every time the reference enable has been high for a number of clock cycles equal to the divisor, the block raises a one-cycle tick. The tick rate is sixteen times the serial bit rate, so the divisor is the reference rate divided by sixteen times the wanted bit rate. Everything runs on the system clock. The reference rate reaches the block only as a per-cycle enable, so no second clock tree is needed.

A write to either divisor byte restarts the count at once from the new divisor. The first period after a rate change therefore never carries on from a stale, long count. A divisor of zero parks the generator with no ticks. A square-ish baud output runs at the tick rate for use by a receiver or for observation.

Top module: `baud_div_gen`

## Requirements
- R1: After reset, both divisor bytes and the count are zero, `tick` and `baud_out` are low, and no tick appears until a nonzero divisor is written.
- R2: A write with `lo_wr` high stores `wr_data` as divisor bits 7:0. A write with `hi_wr` high stores it as divisor bits 15:8. Each write leaves the other byte unchanged.
- R3: With a divisor D of 2 or more and `ref_en` held high, `tick` is high for exactly one cycle in every D cycles.
- R4: A cycle with `ref_en` low neither advances the count nor produces a tick. Only enabled cycles are counted toward the divisor.
- R5: The edge that takes a write to either byte reloads the count with the new divisor, discards any partial count, and ignores `ref_en` for that edge. The first tick then follows the D-th enabled edge after the write.
- R6: With divisor 1, `tick` is high in the cycle after every cycle with `ref_en` high.
- R7: With divisor 0, `tick` never rises, whatever `ref_en` does.
- R8: `baud_out` is a registered level. After each edge it is high when the remaining count is greater than half the divisor (rounded down), and low otherwise. It is always low for divisor 0.
- R9: When `lo_wr` and `hi_wr` are high in the same cycle, both bytes take `wr_data` on that edge, and the combined value drives the reload.
- R10: The largest divisor, 65535, gives its first tick on the 65535th enabled edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en | input | 1 | Reference-rate enable; one count per high cycle |
| lo_wr | input | 1 | Write strobe for divisor bits 7:0 |
| hi_wr | input | 1 | Write strobe for divisor bits 15:8 |
| wr_data | input | 8 | Byte written by either strobe |
| tick | output | 1 | One-cycle pulse at sixteen times the bit rate |
| baud_out | output | 1 | Level at the tick rate, high for the upper half of each period |

## Verification
A wrong count or a wrong latched byte shows up at the ports as a tick in the wrong place. At a short divisor the error appears within a few cycles. At a large divisor it can stay hidden for up to the full divisor of enabled cycles, so the bench also measures first-tick latency for the largest value. `baud_out` exposes the remaining count against half the divisor on every edge. An off-by-one in the count or a wrong reload therefore moves its edges within the same period, long before the next tick. A reference model steps alongside the design on every clock. Directed latency counts check the write-reload, enable-gating and simultaneous-write cases.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

    // Action taken by the counter on the coming edge, in priority order.
    typedef enum logic [2:0] {
        ACT_LOAD = 3'd0,   // divisor byte written: restart from new value
        ACT_IDLE = 3'd1,   // divisor zero: park at zero
        ACT_WRAP = 3'd2,   // enabled at terminal count: tick and reload
        ACT_STEP = 3'd3,   // enabled mid-period: decrement
        ACT_HOLD = 3'd4    // reference enable low: keep count
    } cnt_act_e;

    localparam int unsigned BDG_LANES = 2;

endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LANES  = 2,
    localparam int unsigned DIV_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_q,
    output logic [DIV_W-1:0]  div_d,
    output logic              load
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } latch_t;

    latch_t st_d, st_q;
    logic [DIV_W-1:0] lane_next;

    // One byte lane per strobe; a lane keeps its value unless written.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_next[g*BYTE_W +: BYTE_W] = lane_wr[g] ? wr_data
                                                       : st_q.div[g*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.div = lane_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_q = st_q.div;
    assign div_d = st_d.div;
    assign load  = |lane_wr;

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter
    import baud_div_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             load,
    input  logic [DIV_W-1:0] div_d,
    output logic [DIV_W-1:0] cnt_q,
    output logic [DIV_W-1:0] cnt_d,
    output logic             tick_q
);

    localparam logic [DIV_W-1:0] CNT_ONE  = DIV_W'(1);
    localparam logic [DIV_W-1:0] CNT_ZERO = '0;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } cnt_t;

    cnt_t     st_d, st_q;
    cnt_act_e act;

    // Select the action; a write outranks everything, including ref_en.
    always_comb begin
        if (load) begin
            act = ACT_LOAD;
        end else if (div_d == CNT_ZERO) begin
            act = ACT_IDLE;
        end else if (!ref_en) begin
            act = ACT_HOLD;
        end else if (st_q.cnt <= CNT_ONE) begin
            act = ACT_WRAP;
        end else begin
            act = ACT_STEP;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        unique case (act)
            ACT_LOAD: st_d.cnt = div_d;
            ACT_IDLE: st_d.cnt = CNT_ZERO;
            ACT_WRAP: begin
                st_d.cnt  = div_d;
                st_d.tick = 1'b1;
            end
            ACT_STEP: st_d.cnt = st_q.cnt - CNT_ONE;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q  = st_q.cnt;
    assign cnt_d  = st_d.cnt;
    assign tick_q = st_q.tick;

endmodule

// File: rtl/baud_div_shape.sv
module baud_div_shape #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cnt_d,
    input  logic [DIV_W-1:0] div_d,
    output logic             baud_q
);

    typedef struct packed {
        logic baud;
    } shape_t;

    shape_t st_d, st_q;

    // High while the remaining count sits in the upper half of the period.
    always_comb begin
        st_d      = st_q;
        st_d.baud = cnt_d > (div_d >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign baud_q = st_q.baud;

endmodule

// File: rtl/baud_div_gen.sv
module baud_div_gen
    import baud_div_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned DIV_W = BYTE_W * BDG_LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              tick,
    output logic              baud_out
);

    logic [BDG_LANES-1:0] lane_wr;
    logic [DIV_W-1:0]     div_q;
    logic [DIV_W-1:0]     div_d;
    logic [DIV_W-1:0]     cnt_q;
    logic [DIV_W-1:0]     cnt_d;
    logic                 load;

    assign lane_wr = {hi_wr, lo_wr};

    baud_div_latch #(
        .BYTE_W (BYTE_W),
        .LANES  (BDG_LANES)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_wr (lane_wr),
        .wr_data (wr_data),
        .div_q   (div_q),
        .div_d   (div_d),
        .load    (load)
    );

    baud_div_counter #(
        .DIV_W (DIV_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_en (ref_en),
        .load   (load),
        .div_d  (div_d),
        .cnt_q  (cnt_q),
        .cnt_d  (cnt_d),
        .tick_q (tick)
    );

    baud_div_shape #(
        .DIV_W (DIV_W)
    ) u_shape (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_d  (cnt_d),
        .div_d  (div_d),
        .baud_q (baud_out)
    );

endmodule

// File: rtl/baud_div_gen_chk.sv
module baud_div_gen_chk #(
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_en,
    input logic             lo_wr,
    input logic             hi_wr,
    input logic             tick,
    input logic             baud_out,
    input logic [DIV_W-1:0] div_q,
    input logic [DIV_W-1:0] cnt_q
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    // R7: a parked divisor never lets a tick through.
    a_r7_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |=> !tick);

    // R3: a tick lasts one cycle unless the divisor is one.
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_q != ONE) |=> !tick);

    // R4: with the enable low and no write, the count holds and no tick appears.
    a_r4_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_en && !lo_wr && !hi_wr) |=> ($stable(cnt_q) && !tick));

    // R5: a byte write restarts the count from the new divisor.
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr || hi_wr) |=> (cnt_q == div_q && !tick));

    // R6: divisor one ticks after every enabled cycle.
    a_r6_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == ONE && ref_en && !lo_wr && !hi_wr) |=> tick);

    // R8: baud output stays low while the divisor is zero.
    a_r8_baud_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |-> !baud_out);

endmodule

bind baud_div_gen baud_div_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en   (ref_en),
    .lo_wr    (lo_wr),
    .hi_wr    (hi_wr),
    .tick     (tick),
    .baud_out (baud_out),
    .div_q    (div_q),
    .cnt_q    (cnt_q)
);

// File: tb/baud_div_gen_tb.sv
`timescale 1ns/1ps
module baud_div_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_en = 1'b0;
    logic       lo_wr = 1'b0;
    logic       hi_wr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick;
    logic       baud_out;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_tag = "R1";
    bit    done    = 1'b0;

    always #5 clk = ~clk;

    baud_div_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_en   (ref_en),
        .lo_wr    (lo_wr),
        .hi_wr    (hi_wr),
        .wr_data  (wr_data),
        .tick     (tick),
        .baud_out (baud_out)
    );

    // Behavioural reference: divisor as an integer, remaining enabled cycles.
    int m_div  = 0;
    int m_left = 0;
    bit m_tick = 0;
    bit m_baud = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_div = 0; m_left = 0; m_tick = 0; m_baud = 0;
        end else begin
            if (lo_wr) m_div = (m_div & 32'hFF00) | int'(wr_data);
            if (hi_wr) m_div = (m_div & 32'h00FF) | (int'(wr_data) << 8);
            m_tick = 0;
            if (lo_wr || hi_wr) m_left = m_div;
            else if (m_div == 0) m_left = 0;
            else if (ref_en) begin
                if (m_left <= 1) begin
                    m_tick = 1;
                    m_left = m_div;
                end else begin
                    m_left = m_left - 1;
                end
            end
            m_baud = (m_left > m_div / 2);
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tick == m_tick, cur_tag, "tick vs model", int'(tick), int'(m_tick));
            chk(baud_out == m_baud, "R8", "baud_out vs model", int'(baud_out), int'(m_baud));
        end
    end

    task automatic print_summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired in %s", cur_tag);
        done = 1'b1;
        print_summary();
        $finish;
    end

    task automatic write_div(input bit lo, input bit hi, input logic [7:0] data);
        @(negedge clk);
        lo_wr = lo; hi_wr = hi; wr_data = data;
        @(negedge clk);
        lo_wr = 1'b0; hi_wr = 1'b0;
    endtask

    // Count enabled edges until the first tick; alt gates ref_en every other cycle.
    task automatic first_tick(input int exp, input bit alt, input string tag);
        int n_en = 0;
        bit seen = 0;
        for (int k = 0; k < 140000 && !seen; k++) begin
            ref_en = alt ? k[0] : 1'b1;
            @(negedge clk);
            if (ref_en) n_en++;
            if (tick) seen = 1;
        end
        ref_en = 1'b1;
        chk(seen && n_en == exp, tag, "enabled edges to first tick", n_en, exp);
    endtask

    task automatic count_ticks(input int cycles, input int exp, input string tag);
        int n = 0;
        ref_en = 1'b1;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (tick) n++;
        end
        chk(n == exp, tag, "ticks in window", n, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tick == 1'b0, "R1", "tick in reset", int'(tick), 0);
        chk(baud_out == 1'b0, "R1", "baud_out in reset", int'(baud_out), 0);
        rst_n = 1'b1;
        cur_tag = "R1";
        count_ticks(20, 0, "R1");

        cur_tag = "R2";
        write_div(1'b1, 1'b0, 8'd5);
        first_tick(5, 1'b0, "R2");
        cur_tag = "R3";
        count_ticks(50, 10, "R3");

        cur_tag = "R2";
        write_div(1'b1, 1'b0, 8'd3);
        write_div(1'b0, 1'b1, 8'd1);
        first_tick(259, 1'b0, "R2");

        cur_tag = "R4";
        write_div(1'b1, 1'b0, 8'd4);
        write_div(1'b0, 1'b1, 8'd0);
        first_tick(4, 1'b1, "R4");
        @(negedge clk);
        ref_en = 1'b0;
        count_ticks(0, 0, "R4");
        ref_en = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk(tick == 1'b0, "R4", "tick with enable low", int'(tick), 0);
        end

        cur_tag = "R5";
        write_div(1'b1, 1'b0, 8'd10);
        ref_en = 1'b1;
        repeat (6) @(negedge clk);
        write_div(1'b1, 1'b0, 8'd3);
        first_tick(3, 1'b0, "R5");

        cur_tag = "R6";
        write_div(1'b1, 1'b0, 8'd1);
        count_ticks(10, 10, "R6");
        first_tick(1, 1'b1, "R6");

        cur_tag = "R8";
        write_div(1'b1, 1'b0, 8'd8);
        first_tick(8, 1'b0, "R8");
        begin
            int hi_n = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (baud_out) hi_n++;
            end
            chk(hi_n == 4, "R8", "baud_out high cycles per period", hi_n, 4);
        end

        cur_tag = "R7";
        write_div(1'b1, 1'b0, 8'd0);
        count_ticks(30, 0, "R7");
        chk(baud_out == 1'b0, "R7", "baud_out with divisor zero", int'(baud_out), 0);

        cur_tag = "R9";
        write_div(1'b1, 1'b1, 8'h02);
        first_tick(514, 1'b0, "R9");

        cur_tag = "R10";
        write_div(1'b1, 1'b1, 8'hFF);
        first_tick(65535, 1'b0, "R10");

        repeat (2) @(negedge clk);
        done = 1'b1;
        print_summary();
        $finish;
    end

endmodule